// File: doc/BRIEF.md
# Selectable-Window Pin Deglitcher with Edge Events

This block cleans up one external interrupt and timer-event pin. A divider produces a sampling strobe once every 1, 32 or 128 system clock cycles, selected by a 2-bit field. The raw pin is captured on each strobe. The filtered level changes only when two successive captures agree with each other and differ from the present filtered level. A pulse shorter than one sampling period therefore never gets through. A pulse lasting at least two periods always does.

The filtered level feeds an edge detector. That detector turns accepted transitions into single-cycle event pulses, which the interrupt logic and a counting timer can both use. Rising, falling, both or no transitions can be chosen. Level-sensitive modes are not offered. Changing the window selection restarts the divider. The filtered level is left untouched while that happens, so a new window never produces a spurious transition.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_ni` rises.

Top module: `pin_deglitch_evt`

## Requirements
- R1: After reset the filtered level is 0 and no event pulse is present.
- R2: Window select encoding: 2'b00 samples every cycle, 2'b01 every 32 cycles, 2'b10 and 2'b11 every 128 cycles.
- R3: The filtered level takes a new value only when two consecutive samples agree and differ from it. In the every-cycle window it follows a stable input change two clock edges later. A change held for twice the window length is always accepted.
- R4: A pulse shorter than the window length (1 cycle in the every-cycle window) never changes the filtered level.
- R5: Edge select encoding: 2'b00 produces no events, 2'b01 rising only, 2'b10 falling only, 2'b11 both. The filtered level is produced in every edge mode.
- R6: Each accepted transition that the edge mode selects yields exactly one event pulse, one cycle wide, in the same cycle the filtered level first shows the new value.
- R7: A change of window select restarts the divider and keeps the filtered level as it is. The first sample is taken one full new window after the change, so a steady new input value appears 2K+1 cycles after the change is applied, where K is the new window length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw pin level (already in the clock domain) |
| tc_sel_i | input | 2 | Sampling window select |
| edge_sel_i | input | 2 | Event edge select |
| level_o | output | 1 | Filtered pin level |
| event_o | output | 1 | One-cycle event pulse |

## Verification
Each window setting gets pulses one cycle shorter than the window, which must be dropped, and pulses of exactly twice the window, which must pass. Together these pin down where the rejection and acceptance bounds lie. A window change is applied together with a new input level, and the output is checked one cycle before and exactly at the expected acceptance point. This separates the three window lengths, shows the alias encoding, and shows that the divider restarts. Rise and fall transitions are repeated under each edge mode, and the pulses are counted. This tells the modes apart and shows that no pulse lasts more than one cycle.

// File: rtl/nrf_pkg.sv
package nrf_pkg;
  typedef enum logic [1:0] {
    FS_ONE      = 2'b00,
    FS_MID      = 2'b01,
    FS_SLOW     = 2'b10,
    FS_SLOW_ALT = 2'b11
  } fsel_e;

  typedef enum logic [1:0] {
    EM_NONE = 2'b00,
    EM_RISE = 2'b01,
    EM_FALL = 2'b10,
    EM_BOTH = 2'b11
  } emode_e;
endpackage

// File: rtl/nrf_rst_sync.sv
module nrf_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb stg_d = {stg_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= 2'b00;
    else         stg_q <= stg_d;
  end

  assign rst_no = stg_q[1];
endmodule

// File: rtl/nrf_tick_gen.sv
module nrf_tick_gen
  import nrf_pkg::*;
#(
  parameter int unsigned MID_DIV  = 32,
  parameter int unsigned SLOW_DIV = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  output logic       tick_o,
  output logic       restart_o
);
  localparam int unsigned CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;

  fsel_e         sel_e;
  fsel_e         sel_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] lim;
  logic          cnt_en;

  assign sel_e = fsel_e'(sel_i);

  always_comb begin
    case (sel_e)
      FS_ONE:  lim = '0;
      FS_MID:  lim = CW'(MID_DIV - 1);
      default: lim = CW'(SLOW_DIV - 1);
    endcase
  end

  assign restart_o = (sel_e != sel_q);
  assign tick_o    = !restart_o && (cnt_q == lim);
  assign cnt_en    = 1'b1;

  always_comb begin
    if (restart_o || tick_o) cnt_d = '0;
    else                     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= FS_ONE;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      sel_q <= sel_e;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && lim != '0) |=> !tick_o) else $error("tick spacing"); // R2
endmodule

// File: rtl/nrf_vote.sv
module nrf_vote #(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic restart_i,
  input  logic raw_i,
  output logic filt_o
);
  logic smp_q, smp_d;
  logic filt_q, filt_d;

  always_comb begin
    smp_d  = smp_q;
    filt_d = filt_q;
    if (restart_i) begin
      smp_d = filt_q;
    end else if (tick_i) begin
      smp_d = raw_i;
      if ((raw_i == smp_q) && (raw_i != filt_q)) filt_d = raw_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= RESET_LEVEL;
      filt_q <= RESET_LEVEL;
    end else begin
      smp_q  <= smp_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

  AST_CHANGE_AGREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(raw_i) == filt_q)) else $error("unsupported change"); // R3
  AST_RESTART_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> $stable(filt_q)) else $error("level moved on restart"); // R7
endmodule

// File: rtl/nrf_edge_det.sv
module nrf_edge_det
  import nrf_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [1:0] mode_i,
  output logic       evt_o
);
  logic   prev_q;
  logic   rise, fall;
  emode_e mode_e;

  assign mode_e = emode_e'(mode_i);
  assign rise   = lvl_i & ~prev_q;
  assign fall   = ~lvl_i & prev_q;

  always_comb begin
    case (mode_e)
      EM_RISE: evt_o = rise;
      EM_FALL: evt_o = fall;
      EM_BOTH: evt_o = rise | fall;
      default: evt_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RESET_LEVEL;
    else         prev_q <= lvl_i;
  end
endmodule

// File: rtl/pin_deglitch_evt.sv
module pin_deglitch_evt
  import nrf_pkg::*;
#(
  parameter int unsigned MID_DIV     = 32,
  parameter int unsigned SLOW_DIV    = 128,
  parameter logic        RESET_LEVEL = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] tc_sel_i,
  input  logic [1:0] edge_sel_i,
  output logic       level_o,
  output logic       event_o
);
  logic rst_n_s;
  logic tick;
  logic restart;
  logic filt;

  nrf_rst_sync i_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_s)
  );

  nrf_tick_gen #(
    .MID_DIV (MID_DIV),
    .SLOW_DIV(SLOW_DIV)
  ) i_tick_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .sel_i    (tc_sel_i),
    .tick_o   (tick),
    .restart_o(restart)
  );

  nrf_vote #(
    .RESET_LEVEL(RESET_LEVEL)
  ) i_vote (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .tick_i   (tick),
    .restart_i(restart),
    .raw_i    (pin_i),
    .filt_o   (filt)
  );

  nrf_edge_det #(
    .RESET_LEVEL(RESET_LEVEL)
  ) i_edge_det (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .lvl_i (filt),
    .mode_i(edge_sel_i),
    .evt_o (event_o)
  );

  assign level_o = filt;

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !tick |=> $stable(level_o)) else $error("level moved without strobe"); // R3
  AST_EVT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    event_o |=> !event_o) else $error("event wider than one cycle"); // R6
  AST_EVT_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    event_o |-> (level_o != $past(level_o))) else $error("event without change"); // R6
  AST_NO_EVT_OFF: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (edge_sel_i == 2'b00) |-> !event_o) else $error("event while disabled"); // R5
endmodule

// File: tb/test_pin_deglitch_evt.sv
`timescale 1ns/1ps
module test_pin_deglitch_evt;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin;
  logic [1:0] tc_sel;
  logic [1:0] edge_sel;
  logic       level;
  logic       evt;

  int n_chk  = 0;
  int n_fail = 0;
  int evt_seen = 0;
  int evt_dbl  = 0;
  logic evt_last = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  pin_deglitch_evt i_pin_deglitch_evt (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pin_i     (pin),
    .tc_sel_i  (tc_sel),
    .edge_sel_i(edge_sel),
    .level_o   (level),
    .event_o   (evt)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (evt) evt_seen = evt_seen + 1;
      if (evt && evt_last) evt_dbl = evt_dbl + 1;
      evt_last = evt;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    chk("R1 level after reset", int'(level), 0);
    chk("R1 event after reset", int'(evt), 0);
    step(3);
    chk("R1 level idle", int'(level), 0);
  endtask

  task automatic t_fast();
    int e0;
    tc_sel = 2'b00; edge_sel = 2'b11; step(4);
    e0 = evt_seen;
    pin = 1'b1; step(1); pin = 1'b0; step(4);
    chk("R4 one-cycle glitch dropped", int'(level), 0);
    chk("R4 no event for glitch", evt_seen - e0, 0);
    pin = 1'b1; step(1);
    chk("R3 not yet after one edge", int'(level), 0);
    step(1);
    chk("R3 accepted after two edges", int'(level), 1);
    chk("R6 event with new level", int'(evt), 1);
    step(1);
    chk("R6 event one cycle", int'(evt), 0);
    pin = 1'b0; step(2);
    chk("R3 fall accepted", int'(level), 0);
    chk("R5 both edges counted", evt_seen - e0, 2);
  endtask

  task automatic t_window(input logic [1:0] sel, input int k, input string tag);
    int e0;
    tc_sel = sel; edge_sel = 2'b11; pin = 1'b0; step(3);
    e0 = evt_seen;
    pin = 1'b1; step(k - 1); pin = 1'b0; step(3 * k);
    chk({tag, " R4 short pulse dropped"}, int'(level), 0);
    chk({tag, " R4 no event"}, evt_seen - e0, 0);
    pin = 1'b1; step(2 * k);
    chk({tag, " R3 double window accepted"}, int'(level), 1);
    pin = 1'b0; step(2 * k);
    chk({tag, " R3 fall accepted"}, int'(level), 0);
    chk({tag, " R6 two events"}, evt_seen - e0, 2);
  endtask

  task automatic t_restart(input logic [1:0] sel, input int k, input string tag);
    tc_sel = 2'b00; edge_sel = 2'b11; pin = 1'b0; step(4);
    chk({tag, " R7 start low"}, int'(level), 0);
    tc_sel = sel; pin = 1'b1; step(2 * k);
    chk({tag, " R7 held until 2K"}, int'(level), 0);
    step(1);
    chk({tag, " R2 accepted at 2K+1"}, int'(level), 1);
    tc_sel = 2'b00; pin = 1'b0; step(2);
    chk({tag, " R7 holds across restart"}, int'(level), 1);
    step(1);
    chk({tag, " R7 fast after restart"}, int'(level), 0);
  endtask

  task automatic t_modes();
    int e0, e1;
    tc_sel = 2'b00; pin = 1'b0;
    edge_sel = 2'b01; step(3); e0 = evt_seen;
    pin = 1'b1; step(3); e1 = evt_seen;
    pin = 1'b0; step(3);
    chk("R5 rise mode on rise", e1 - e0, 1);
    chk("R5 rise mode on fall", evt_seen - e1, 0);
    edge_sel = 2'b10; e0 = evt_seen;
    pin = 1'b1; step(3); e1 = evt_seen;
    pin = 1'b0; step(3);
    chk("R5 fall mode on rise", e1 - e0, 0);
    chk("R5 fall mode on fall", evt_seen - e1, 1);
    edge_sel = 2'b00; e0 = evt_seen;
    pin = 1'b1; step(3);
    chk("R5 level follows when events off", int'(level), 1);
    pin = 1'b0; step(3);
    chk("R5 no events when off", evt_seen - e0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin = 1'b0; tc_sel = 2'b00; edge_sel = 2'b11;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fast();
    t_window(2'b01, 32, "mid");
    t_window(2'b10, 128, "slow");
    t_restart(2'b01, 32, "mid");
    t_restart(2'b10, 128, "slow");
    t_restart(2'b11, 128, "alias");
    t_modes();
    chk("R6 no double-wide event", evt_dbl, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule